// File: doc/BRIEF.md
# Horizontal OSD Character Timing Generator

This block derives the horizontal timing of one on-screen-display text row from the pixel clock. A rising edge on the horizontal flyback input starts a line. The block then waits a start delay that is an affine function of a programmable position value. After the delay it sweeps a window of 360 pixel clocks and reports which character column and which dot inside that character is being drawn, together with a flag that marks the active window.

Each character is 12 dots wide and a row holds 30 characters. When double width is selected, each dot is held for two pixel clocks. Only the even columns are reported, so 15 wide characters fill the same 360-clock span. The position value and the width choice are captured at the flyback edge, so software can update them at any time without disturbing the line in progress. Font lookup, colour and vertical timing sit downstream.

Top module: `osd_htiming`

## Requirements
- R1: During reset and after it, with no flyback edge seen, `active_o` is 0 and `col_o` and `dot_o` are 0. An asynchronous reset in the middle of a line returns all outputs to 0 at once.
- R2: The leading edge is the first rising clock edge at which `hflb_i` is sampled 1 after being sampled 0. Call this edge E. `active_o` is 0 through edge E+D-1 and is 1 after edge E+D, where D = `hdelay_i`*6+49.
- R3: With double width off, the active window lasts exactly 360 clocks. `dot_o` steps 0..11 once per clock, and `col_o` steps 0..29, advancing when `dot_o` wraps from 11.
- R4: With double width on, the active window lasts exactly 360 clocks. Each `dot_o` value (0..11) is held for two clocks, and `col_o` takes only the even values 0,2,..,28.
- R5: Outside the active window, `active_o` is 0 and `col_o` and `dot_o` are 0. This includes the start delay and the time after the last dot of a line.
- R6: A new leading edge of `hflb_i` restarts the delay at once, even during the delay or the active window of the current line.
- R7: Holding `hflb_i` at 1 for any number of clocks causes exactly one restart. Only the 0-to-1 transition counts.
- R8: `hdelay_i` and `dbl_wide_i` are sampled at the leading edge. Changes made after it have no effect until the next leading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hflb_i | input | 1 | Horizontal flyback, active high; its rising edge starts a line |
| hdelay_i | input | 7 | Horizontal position value; start delay = value*6+49 clocks |
| dbl_wide_i | input | 1 | Double-width select for the row being drawn |
| active_o | output | 1 | High during the 360-clock display window |
| col_o | output | 5 | Character column index |
| dot_o | output | 4 | Dot index inside the current character |

## Verification
Every clock of each line is compared against a closed-form expectation for the delay, column and dot. This covers the shortest delay (value 0) and the longest (value 127). A design with an off-by-one load would raise the active flag a clock early or late. One that miscounted the window would leave it high past dot 11 of the last column. Double width is checked for both the two-clock dot hold and the even-only column sequence; a design that got this wrong would show odd columns or end the window after 180 or 720 clocks. Further directed cases cover the following, each with its failure mode:
- A flyback held high for a whole line, where a level-sensitive design would stall in the delay.
- A restart in the middle of the active window, where a design that ignored it would finish the old line.
- Changes to the position and width inputs just after the edge, where a design that read them live would move the window.
- A reset in the middle of a line.

// File: rtl/osd_htiming_pkg.sv
package osd_htiming_pkg;
  localparam int unsigned DOTS_PER_CHAR = 12;
  localparam int unsigned NUM_COLS      = 30;
  localparam int unsigned DELAY_MUL     = 6;
  localparam int unsigned DELAY_OFS     = 49;
  localparam int unsigned HDELAY_W      = 7;
endpackage

// File: rtl/osd_flb_edge.sv
module osd_flb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flb_i,
  output logic edge_o
);
  logic flb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flb_q <= 1'b0;
    else         flb_q <= flb_i;
  end

  assign edge_o = flb_i & ~flb_q;
endmodule

// File: rtl/osd_hdelay_cnt.sv
module osd_hdelay_cnt #(
  parameter int unsigned HD_W  = 7,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned DMUL  = 6,
  parameter int unsigned DOFS  = 49
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic [HD_W-1:0] hdelay_i,
  output logic            busy_o,
  output logic            start_o
);
  logic [CNT_W-1:0] dly_len;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_comb dly_len = CNT_W'(hdelay_i) * CNT_W'(DMUL) + CNT_W'(DOFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (restart_i) begin
      busy_q <= 1'b1;
      cnt_q  <= dly_len - CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o  = busy_q;
  assign start_o = busy_q && (cnt_q == '0) && !restart_i;

  // R2 / R6: an edge always (re)opens the delay phase
  a_r2_restart_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> busy_o);

  // R2: the start pulse ends the delay phase
  a_r2_start_ends_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !busy_o);
endmodule

// File: rtl/osd_dotcol_cnt.sv
module osd_dotcol_cnt #(
  parameter int unsigned COLS    = 30,
  parameter int unsigned DOT_PIX = 12,
  parameter int unsigned COL_W   = 5,
  parameter int unsigned DOT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             start_i,
  input  logic             dbl_i,
  output logic             active_o,
  output logic [COL_W-1:0] col_o,
  output logic [DOT_W-1:0] dot_o
);
  logic             active_q, half_q, dbl_q;
  logic [COL_W-1:0] col_q;
  logic [DOT_W-1:0] dot_q;
  logic             dot_adv, last_dot, last_col;
  logic [COL_W-1:0] col_step;

  always_comb begin
    dot_adv  = !dbl_q || half_q;
    last_dot = (dot_q == DOT_W'(DOT_PIX - 1));
    last_col = dbl_q ? (col_q == COL_W'(COLS - 2)) : (col_q == COL_W'(COLS - 1));
    col_step = dbl_q ? COL_W'(2) : COL_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      dbl_q    <= 1'b0;
      col_q    <= '0;
      dot_q    <= '0;
    end else if (restart_i) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      dbl_q    <= dbl_i;
      col_q    <= '0;
      dot_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      half_q   <= 1'b0;
      col_q    <= '0;
      dot_q    <= '0;
    end else if (active_q) begin
      half_q <= dbl_q && !half_q;
      if (dot_adv) begin
        if (last_dot) begin
          dot_q <= '0;
          if (last_col) begin
            active_q <= 1'b0;
            col_q    <= '0;
          end else begin
            col_q <= col_q + col_step;
          end
        end else begin
          dot_q <= dot_q + DOT_W'(1);
        end
      end
    end
  end

  assign active_o = active_q;
  assign col_o    = col_q;
  assign dot_o    = dot_q;

  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (col_o == '0) && (dot_o == '0));

  a_r3_dot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_o <= DOT_W'(DOT_PIX - 1));

  a_r3_dot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !dbl_q && !restart_i && !last_dot |=> dot_o == $past(dot_o) + DOT_W'(1));

  a_r4_even_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && dbl_q |-> !col_o[0]);

  a_r4_dot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && dbl_q && !half_q && !restart_i |=> active_o && $stable(dot_o));
endmodule

// File: rtl/osd_htiming.sv
module osd_htiming
  import osd_htiming_pkg::*;
#(
  parameter int unsigned HD_W    = HDELAY_W,
  parameter int unsigned COLS    = NUM_COLS,
  parameter int unsigned DOT_PIX = DOTS_PER_CHAR,
  parameter int unsigned DMUL    = DELAY_MUL,
  parameter int unsigned DOFS    = DELAY_OFS,
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned DOT_W  = $clog2(DOT_PIX),
  localparam int unsigned CNT_W  = $clog2(((1 << HD_W) - 1) * DMUL + DOFS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hflb_i,
  input  logic [HD_W-1:0]  hdelay_i,
  input  logic             dbl_wide_i,
  output logic             active_o,
  output logic [COL_W-1:0] col_o,
  output logic [DOT_W-1:0] dot_o
);
  logic flb_edge, dly_busy, dly_start;

  osd_flb_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flb_i  (hflb_i),
    .edge_o (flb_edge)
  );

  osd_hdelay_cnt #(
    .HD_W (HD_W), .CNT_W (CNT_W), .DMUL (DMUL), .DOFS (DOFS)
  ) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (flb_edge),
    .hdelay_i  (hdelay_i),
    .busy_o    (dly_busy),
    .start_o   (dly_start)
  );

  osd_dotcol_cnt #(
    .COLS (COLS), .DOT_PIX (DOT_PIX), .COL_W (COL_W), .DOT_W (DOT_W)
  ) u_dotcol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (flb_edge),
    .start_i   (dly_start),
    .dbl_i     (dbl_wide_i),
    .active_o  (active_o),
    .col_o     (col_o),
    .dot_o     (dot_o)
  );

  a_r2_quiet_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_busy |-> !active_o);

  a_r6_edge_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flb_edge |=> !active_o && dly_busy);
endmodule

// File: tb/osd_htiming_bench.sv
module osd_htiming_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hflb_i = 1'b0;
  logic [6:0] hdelay_i = '0;
  logic       dbl_wide_i = 1'b0;
  logic       active_o;
  logic [4:0] col_o;
  logic [3:0] dot_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  osd_htiming u_osd_htiming (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hflb_i     (hflb_i),
    .hdelay_i   (hdelay_i),
    .dbl_wide_i (dbl_wide_i),
    .active_o   (active_o),
    .col_o      (col_o),
    .dot_o      (dot_o)
  );

  // stimulus vectors: delay value, double width, flyback high clocks (0 = never dropped), change inputs after edge
  localparam int V_N = 6;
  localparam int unsigned V_HD   [V_N] = '{0, 127, 20, 5, 64, 33};
  localparam bit          V_DBL  [V_N] = '{0, 0, 1, 1, 0, 1};
  localparam int unsigned V_HOLD [V_N] = '{4, 4, 4, 0, 3, 1};
  localparam bit          V_CHG  [V_N] = '{0, 0, 0, 0, 1, 1};

  function automatic logic [9:0] exp_out(int n, int d, bit dbl);
    int p;
    if (n < d || n >= d + 360) return '0;
    p = n - d;
    if (!dbl) return {1'b1, 5'(p / 12), 4'(p % 12)};
    return {1'b1, 5'(2 * (p / 24)), 4'((p % 24) / 2)};
  endfunction

  task automatic check(string tag, logic [9:0] exp, int n);
    logic [9:0] got;
    got = {active_o, col_o, dot_o};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s n=%0d got act=%0b col=%0d dot=%0d exp act=%0b col=%0d dot=%0d",
               tag, n, got[9], got[8:4], got[3:0], exp[9], exp[8:4], exp[3:0]);
    end
  endtask

  task automatic run_line(int hd, bit dbl, int ncyc, int hold, bit chg, string tag_ovr);
    int d;
    string tag;
    d = hd * 6 + 49;
    @(negedge clk_i);
    hflb_i = 1'b0; hdelay_i = 7'(hd); dbl_wide_i = dbl;
    @(negedge clk_i);
    hflb_i = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk_i);
      if (tag_ovr != "")         tag = tag_ovr;
      else if (hold == 0)        tag = "R7";
      else if (chg)              tag = "R8";
      else if (n < d)            tag = "R2";
      else if (n >= d + 360)     tag = "R5";
      else                       tag = dbl ? "R4" : "R3";
      check(tag, exp_out(n, d, dbl), n);
      if (hold != 0 && n + 1 == hold) hflb_i = 1'b0;
      if (chg && n == 4) begin
        hdelay_i   = 7'(hd + 37);
        dbl_wide_i = !dbl;
      end
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk_i);
      check("R1", '0, -1);
    end
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      check("R1", '0, -1);
    end

    for (int i = 0; i < V_N; i++)
      run_line(int'(V_HD[i]), V_DBL[i], int'(V_HD[i]) * 6 + 49 + 366,
               int'(V_HOLD[i]), V_CHG[i], "");

    // R6: restart in the middle of the active window, then in the delay
    run_line(10, 1'b0, 150, 4, 1'b0, "R6");
    run_line(30, 1'b1, 60, 4, 1'b0, "R6");
    run_line(3, 1'b1, 3 * 6 + 49 + 366, 4, 1'b0, "R6");

    // R1: asynchronous reset in the middle of a line
    run_line(0, 1'b0, 100, 4, 1'b0, "R3");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", '0, -1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) begin
      @(negedge clk_i);
      check("R1", '0, -1);
    end
    run_line(2, 1'b0, 2 * 6 + 49 + 366, 4, 1'b0, "");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule